// File: doc/BRIEF.md
# ECC Syndrome Classifier and Single-Bit Corrector

This block compares the 22-bit check code stored alongside a 256-byte data chunk with the code freshly computed over the same chunk when it is read back. It forms the syndrome and counts its set bits. It then sorts the read into one of four outcomes:

- the chunk is clean;
- only the stored check code is damaged;
- exactly one data bit is wrong and can be repaired;
- the damage is beyond repair.

For a repairable chunk it names the failing byte and gives a one-hot mask of the failing bit. When the repair port is enabled, it also emits a single write strobe with that address and mask. A buffer controller can then flip the bit in place with a read-modify-write.

A 512-byte page is handled as two 256-byte halves that are presented one after the other. The second half is presented with the chain input raised. A sticky fail flag then carries the OR of both halves' return flags, so software can see the page result in one read.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: When the stored and computed codes are equal (zero syndrome), the result class is clean (status 2'b00), retFlag is 0, and byteIdx and bitMask are 0.
- R2: When either the stored code or the computed code is all zeros, the result class is clean (2'b00) whatever the syndrome, with retFlag 0.
- R3: When exactly one syndrome bit is set (and R2 does not apply), the class is ECC-only (status 2'b01) and retFlag is 1. No data repair is signalled: bitMask is 0 and fixWe stays low.
- R4: When the syndrome has exactly 11 set bits and (stored[10:0]^stored[21:11]) ^ (computed[10:0]^computed[21:11]) equals 11'h7FF, the class is repairable (status 2'b10) and retFlag is 0. byteIdx equals syndrome[10:3], and bitMask equals 1 shifted left by syndrome[2:0].
- R5: Every other nonzero syndrome is uncorrectable (status 2'b11), with retFlag 1 and byteIdx and bitMask 0.
- R6: A result appears together with a one-cycle done pulse in the cycle after the clock edge that samples start high. All result outputs then hold their values until the next start.
- R7: With FIX_PORT_EN=1, fixWe pulses for exactly that one cycle when the class is repairable, with fixAddr = byteIdx and fixMask = bitMask. It is never raised for any other class.
- R8: On a start with chainIn=0, failAcc takes the new retFlag. On a start with chainIn=1, failAcc becomes its previous value ORed with the new retFlag.
- R9: After reset, status is 2'b00, and done, retFlag, failAcc, fixWe, byteIdx and bitMask are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Samples both codes and starts one classification |
| chainIn | input | 1 | 1: OR this chunk's retFlag into failAcc; 0: restart failAcc |
| storedCode | input | 22 | Check code read from the spare area |
| calcCode | input | 22 | Check code computed over the chunk just read |
| done | output | 1 | One-cycle pulse when a new result is valid |
| status | output | 2 | 00 clean, 01 ECC-only, 10 repairable, 11 uncorrectable |
| retFlag | output | 1 | 1 for ECC-only or uncorrectable |
| failAcc | output | 1 | Sticky OR of retFlag over a chained sequence |
| byteIdx | output | 8 | Failing byte for a repairable chunk, else 0 |
| bitMask | output | 8 | One-hot failing bit for a repairable chunk, else 0 |
| fixWe | output | 1 | Write strobe for the in-place repair |
| fixAddr | output | 8 | Byte address for the repair write |
| fixMask | output | 8 | XOR mask for the repair write |

## Verification
A wrong population count or a wrong pair test shows up as the wrong status code in the cycle right after the start. Typical symptoms are an 11-bit syndrome that fails the pair test being called repairable, or a damaged code being read as clean. A mis-sliced syndrome field shows as a wrong byteIdx or bitMask on that same cycle, and as a repair write to the wrong location. A broken hold or chain register shows one cycle later: the idle cycle after each result must repeat it unchanged, and failAcc must survive a chained clean chunk.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAN   = 2'b00,
    CLS_ECCONLY = 2'b01,
    CLS_FIXED   = 2'b10,
    CLS_UNCORR  = 2'b11
  } eccClass_e;

  typedef struct packed {
    logic load;
    logic accClear;
  } dpStrobe_t;
endpackage

// File: rtl/ecc_syn_ctl.sv
module ecc_syn_ctl
  import ecc_syn_pkg::*;
#(
  parameter bit FIX_PORT_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       chainIn,
  input  logic       fixable,
  output dpStrobe_t  stb,
  output logic       done,
  output logic       fixWe
);
  always_comb begin
    stb.load     = start;
    stb.accClear = start & ~chainIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done  <= 1'b0;
      fixWe <= 1'b0;
    end else begin
      done  <= start;
      fixWe <= FIX_PORT_EN & start & fixable;
    end
  end

  // R6
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);
  // R7
  fix_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    fixWe |-> done);
endmodule

// File: rtl/ecc_syn_dp.sv
module ecc_syn_dp
  import ecc_syn_pkg::*;
#(
  parameter int CODE_W = 22
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            stb,
  input  logic [CODE_W-1:0]    storedCode,
  input  logic [CODE_W-1:0]    calcCode,
  output logic                 fixable,
  output logic [1:0]           status,
  output logic                 retFlag,
  output logic                 failAcc,
  output logic [CODE_W/2-4:0]  byteIdx,
  output logic [7:0]           bitMask
);
  localparam int HALF_W = CODE_W / 2;
  localparam int BYTE_W = HALF_W - 3;
  localparam int POP_W  = $clog2(CODE_W + 1);
  localparam logic [POP_W-1:0] POP_ONE  = POP_W'(1);
  localparam logic [POP_W-1:0] POP_HALF = POP_W'(HALF_W);

  logic [CODE_W-1:0] syn;
  logic [POP_W-1:0]  popCnt;
  logic [HALF_W-1:0] foldStored, foldCalc;
  logic              anyZero, pairOk;
  eccClass_e         nextCls;
  logic              nextRet;

  function automatic logic [POP_W-1:0] popCount(input logic [CODE_W-1:0] v);
    logic [POP_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < CODE_W; i++) acc = acc + POP_W'(v[i]);
    return acc;
  endfunction

  always_comb begin
    syn        = storedCode ^ calcCode;
    popCnt     = popCount(syn);
    foldStored = storedCode[HALF_W-1:0] ^ storedCode[CODE_W-1:HALF_W];
    foldCalc   = calcCode[HALF_W-1:0] ^ calcCode[CODE_W-1:HALF_W];
    pairOk     = &(foldStored ^ foldCalc);
    anyZero    = (syn == '0) || (storedCode == '0) || (calcCode == '0);
    if (anyZero)                                nextCls = CLS_CLEAN;
    else if (popCnt == POP_ONE)                 nextCls = CLS_ECCONLY;
    else if (popCnt == POP_HALF && pairOk)      nextCls = CLS_FIXED;
    else                                        nextCls = CLS_UNCORR;
    fixable = (nextCls == CLS_FIXED);
    nextRet = (nextCls == CLS_ECCONLY) || (nextCls == CLS_UNCORR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status  <= CLS_CLEAN;
      retFlag <= 1'b0;
      failAcc <= 1'b0;
      byteIdx <= '0;
      bitMask <= '0;
    end else if (stb.load) begin
      status  <= nextCls;
      retFlag <= nextRet;
      failAcc <= stb.accClear ? nextRet : (failAcc | nextRet);
      byteIdx <= fixable ? syn[HALF_W-1:3] : '0;
      bitMask <= fixable ? (8'h01 << syn[2:0]) : 8'h00;
    end
  end

  // R4
  fixed_mask_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == CLS_FIXED) |-> $onehot(bitMask));
  // R5
  nofix_zero_loc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status != CLS_FIXED) |-> (bitMask == 8'h00 && byteIdx == '0));
  // R3
  ecconly_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == CLS_ECCONLY) |-> retFlag);
  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(status) && $stable(byteIdx) && $stable(bitMask)
                   && $stable(failAcc)));
  // R8
  chain_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !stb.accClear && failAcc) |=> failAcc);
endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
  import ecc_syn_pkg::*;
#(
  parameter int CODE_W      = 22,
  parameter bit FIX_PORT_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                chainIn,
  input  logic [CODE_W-1:0]   storedCode,
  input  logic [CODE_W-1:0]   calcCode,
  output logic                done,
  output logic [1:0]          status,
  output logic                retFlag,
  output logic                failAcc,
  output logic [CODE_W/2-4:0] byteIdx,
  output logic [7:0]          bitMask,
  output logic                fixWe,
  output logic [CODE_W/2-4:0] fixAddr,
  output logic [7:0]          fixMask
);
  dpStrobe_t stb;
  logic      fixable;

  ecc_syn_ctl #(.FIX_PORT_EN(FIX_PORT_EN)) i_ctl (
    .clk(clk), .rstN(rstN), .start(start), .chainIn(chainIn),
    .fixable(fixable), .stb(stb), .done(done), .fixWe(fixWe)
  );

  ecc_syn_dp #(.CODE_W(CODE_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .storedCode(storedCode),
    .calcCode(calcCode), .fixable(fixable), .status(status),
    .retFlag(retFlag), .failAcc(failAcc), .byteIdx(byteIdx), .bitMask(bitMask)
  );

  assign fixAddr = byteIdx;
  assign fixMask = bitMask;

  // R7
  fix_only_when_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    fixWe |-> (status == CLS_FIXED && fixMask != 8'h00));
endmodule

// File: tb/test_ecc_syndrome_fixer.sv
module test_ecc_syndrome_fixer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        chainIn = 1'b0;
  logic [21:0] storedCode = '0;
  logic [21:0] calcCode = '0;
  logic        done, retFlag, failAcc, fixWe;
  logic [1:0]  status;
  logic [7:0]  byteIdx, bitMask, fixAddr, fixMask;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit finished = 1'b0;
  logic modelAcc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  ecc_syndrome_fixer i_ecc_syndrome_fixer (
    .clk(clk), .rstN(rstN), .start(start), .chainIn(chainIn),
    .storedCode(storedCode), .calcCode(calcCode), .done(done),
    .status(status), .retFlag(retFlag), .failAcc(failAcc),
    .byteIdx(byteIdx), .bitMask(bitMask), .fixWe(fixWe),
    .fixAddr(fixAddr), .fixMask(fixMask)
  );

  function automatic logic [1:0] expClass(input logic [21:0] s, input logic [21:0] c);
    logic [21:0] y;
    logic [10:0] f;
    y = s ^ c;
    f = (s[10:0] ^ s[21:11]) ^ (c[10:0] ^ c[21:11]);
    if (y == 0 || s == 0 || c == 0) return 2'b00;
    if ($countones(y) == 1) return 2'b01;
    if ($countones(y) == 11 && f == 11'h7FF) return 2'b10;
    return 2'b11;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runVec(input logic [21:0] s, input logic [21:0] c, input logic ch);
    logic [1:0]  cls;
    logic [21:0] y;
    logic        ret;
    logic [7:0]  eIdx, eMask;
    string       req;
    y   = s ^ c;
    cls = expClass(s, c);
    ret = (cls == 2'b01) || (cls == 2'b11);
    eIdx  = (cls == 2'b10) ? y[10:3] : 8'h00;
    eMask = (cls == 2'b10) ? (8'h01 << y[2:0]) : 8'h00;
    modelAcc = ch ? (modelAcc | ret) : ret;
    if (y == 0) req = "R1";
    else if (s == 0 || c == 0) req = "R2";
    else if (cls == 2'b01) req = "R3";
    else if (cls == 2'b10) req = "R4";
    else req = "R5";
    storedCode = s; calcCode = c; chainIn = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " class/flag/idx/mask"}, {done, status, retFlag, byteIdx, bitMask},
          {1'b1, cls, ret, eIdx, eMask});
    // R7 repair write port
    check("R7 fix port", {fixWe, fixAddr, fixMask},
          {(cls == 2'b10), eIdx, eMask});
    // R8 chained fail flag
    check("R8 failAcc", failAcc, modelAcc);
    storedCode = ~s; calcCode = s;
    @(negedge clk);
    // R6 done drops, result held
    check("R6 hold", {done, fixWe, status, retFlag, byteIdx, bitMask, failAcc},
          {2'b00, cls, ret, eIdx, eMask, modelAcc});
  endtask

  initial begin
    logic [21:0] lcg;
    repeat (2) @(negedge clk);
    // R9 reset state
    check("R9 reset", {done, status, retFlag, failAcc, fixWe, byteIdx, bitMask}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {done, status, fixWe}, '0);

    // R1 / R2 zero cases
    runVec(22'h12345, 22'h12345, 1'b0);
    runVec(22'h0, 22'h3ABCDE, 1'b0);
    runVec(22'h2A5A5A, 22'h0, 1'b0);
    runVec(22'h0, 22'h0, 1'b0);
    // R3 every single-bit syndrome
    for (int b = 0; b < 22; b++) runVec(22'h1C3A5F, 22'h1C3A5F ^ (22'h1 << b), 1'b0);
    // R4 every correctable error location
    for (int e = 0; e < 2048; e++) begin
      logic [10:0] p;
      logic [21:0] s;
      p = 11'(e);
      s = 22'h2B6D1 ^ 22'(e * 37);
      runVec(s, s ^ {~p, p}, 1'b0);
    end
    // R5 eleven ones that fail the pair test, plus two-bit syndromes
    runVec(22'h155555, 22'h155555 ^ 22'h0017FE, 1'b0);
    runVec(22'h0F0F0F, 22'h0F0F0F ^ 22'h000003, 1'b0);
    runVec(22'h0F0F0F, 22'h0F0F0F ^ 22'h3FFFFF, 1'b0);
    // R8 chained halves: failing then clean, clean then failing
    runVec(22'h0F0F0F, 22'h0F0F0F ^ 22'h000003, 1'b0);
    runVec(22'h123456, 22'h123456, 1'b1);
    runVec(22'h123456, 22'h123456, 1'b0);
    runVec(22'h1, 22'h3, 1'b1);
    // pseudo-random sweep over all classes
    lcg = 22'h2F1A3;
    for (int k = 0; k < 1500; k++) begin
      logic [21:0] a;
      lcg = lcg * 22'd1103515 + 22'd12345;
      a = lcg;
      lcg = lcg * 22'd1103515 + 22'd12345;
      case (k % 4)
        0: runVec(a, lcg, k[2]);
        1: runVec(a, a ^ (22'h1 << (k % 22)), k[3]);
        2: runVec(a, a ^ {~lcg[10:0], lcg[10:0]}, k[2]);
        default: runVec(a, a ^ (lcg & 22'h0000FF), k[3]);
      endcase
    end
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule